// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets a host run one clause-22 management transaction on the MDC/MDIO pair per command. The host writes a packed command word holding the PHY address, the PHY register number, the direction and a start bit. The controller then shifts out a full 64-bit management frame. For a read, it releases the data line at turnaround and captures sixteen bits from the PHY. The busy bit in the command word stays set until the last MDC cycle ends, and the host polls it to learn that the transaction is finished.

The data word sits four bytes above the command word. On a write transaction, the controller does not latch this word when the command is accepted. Each data bit is taken from the data word in the MDC low phase where that bit is driven. The host can therefore write the command first and the value afterwards, as long as the value arrives before the data field begins. On a read, the captured value is copied into the data word in the same cycle that busy clears.

The frame sequencer is a three-state machine:
- `ST_IDLE`: MDC is low and the pin is released.
- `ST_LOW`: the current bit is driven while MDC is low.
- `ST_HIGH`: MDC is high.

Transitions:
- `start`: ST_IDLE to ST_LOW, taken when a command is accepted.
- `rise`: ST_LOW to ST_HIGH, taken when the divider tick ends the low phase. On a read, the input is sampled on this transition.
- `fall`: ST_HIGH to ST_LOW, taken on a tick when more bits remain; the bit index advances.
- `done`: ST_HIGH to ST_IDLE, taken on the tick that ends the last bit.

Each MDC phase lasts `div_half + 1` system clocks.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: The command word is read at byte address 0 (`host_addr[2]` = 0). Its fields are:
  - bit 0: busy
  - bit 1: direction (1 = write, 0 = read)
  - bits 8:4: PHY register number
  - bits 16:12: PHY address
  - all other bits read as 0.
- R2: Writing the command word with bit 0 = 1 while idle starts a frame. Busy reads 1 from the next cycle until the frame's last MDC high phase ends, and then reads 0.
- R3: A command write that arrives while busy is 1 is ignored. The stored fields are unchanged, and the running frame continues unaltered with exactly 64 MDC rising edges.
- R4: A frame is 64 bits, sent MSB first and shown on the line at MDC rising edges, in this order:
  - 32 ones
  - start code 01
  - opcode 10 for a read, 01 for a write
  - 5-bit PHY address
  - 5-bit register number
  - 2 turnaround bits
  - 16 data bits
- R5: The data word is at byte address 4 (`host_addr[2]` = 1) in bits 15:0 and reads back what was written. On a write frame, each data bit is taken from this word when that bit is driven. A value written after the command, but before the data field starts, is the value that is sent.
- R6: On a read frame, `mdio_oe` is 0 from the first turnaround bit through the last data bit. `mdio_i` is sampled as MDC rises, and the 16 sampled bits appear in the data word once busy is 0.
- R7: On a write frame, `mdio_oe` is 1 for all 64 bits, and the turnaround is driven as 1 then 0.
- R8: Each MDC high phase and each low phase lasts `div_half + 1` system clocks; `div_half` = 9 at 50 MHz gives 2.5 MHz. While idle, MDC is 0 and `mdio_oe` is 0.
- R9: After reset, the command word reads 0, MDC is 0 and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 3 | Byte address; bit 2 selects the data word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the addressed word |
| div_half | input | 8 | MDC half-period minus one, in system clocks |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest case to reach is a write frame whose data word changes after the command has been accepted. It only shows a difference if the bits sent match the late value and not the value present at acceptance. The bench reaches it by writing the data word about two hundred cycles into the preamble, after a different earlier value. A second hard case is a command write that lands mid-frame. The bench issues it while a read is shifting, then checks the command readback, the captured frame and the count of MDC rising edges. A behavioural PHY in the bench drives the turnaround zero and the data on MDC falling edges, and it flags any cycle in which both sides drive the line.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } mdio_state_e;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int PRE_BITS   = 32;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;
    localparam int DATA_W     = 16;
    localparam int FIELD_W    = 5;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == div_half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic              dir_wr,
    input  logic              mdio_i,
    output mdio_state_e       state_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              done,
    output logic [DATA_W-1:0] rd_word
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_FIRST);

    mdio_state_e       state_d;
    logic [IDX_W-1:0]  idx_d;
    logic [DATA_W-1:0] shift_q, shift_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        shift_d = shift_q;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_LOW;
                    idx_d   = '0;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    state_d = ST_HIGH;
                    if (!dir_wr && idx_q >= DATA_IDX)
                        shift_d = {shift_q[DATA_W-2:0], mdio_i};
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                        done    = 1'b1;
                    end else begin
                        state_d = ST_LOW;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            shift_q <= shift_d;
        end
    end

    assign rd_word = shift_q;

    // R8: an MDC phase only ends on a divider tick
    p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !tick) |=> $stable(state_q))
        else $error("p_phase_hold_r8");

    // R2: the tick that ends the last high phase returns to idle
    p_last_bit_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && tick && idx_q == LAST_IDX) |=> state_q == ST_IDLE)
        else $error("p_last_bit_done_r2");

    // R4: every falling edge inside the frame moves to the next bit
    p_bit_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && tick && idx_q != LAST_IDX) |=> idx_q == $past(idx_q) + 1'b1)
        else $error("p_bit_advance_r4");
endmodule

// File: rtl/mdio_bit_mux.sv
module mdio_bit_mux
    import mdio_cmd_pkg::*;
(
    input  mdio_state_e        state,
    input  logic [IDX_W-1:0]   idx,
    input  logic               dir_wr,
    input  logic [FIELD_W-1:0] phy,
    input  logic [FIELD_W-1:0] regn,
    input  logic [DATA_W-1:0]  wdata,
    output logic               mdio_o,
    output logic               mdio_oe
);
    logic [15:0] hdr;
    logic        active;

    assign active = (state != ST_IDLE);
    assign hdr    = {2'b01, (dir_wr ? 2'b01 : 2'b10), phy, regn, 2'b10};

    always_comb begin
        if (idx < IDX_W'(PRE_BITS))
            mdio_o = 1'b1;
        else if (idx < IDX_W'(DATA_FIRST))
            mdio_o = hdr[~idx[3:0]];
        else
            mdio_o = wdata[~idx[3:0]];
        mdio_oe = active && (dir_wr || idx < IDX_W'(TA_FIRST));
    end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_cmd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_en,
    input  logic             host_we,
    input  logic [2:0]       host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    input  logic [DIV_W-1:0] div_half,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    mdio_state_e        state;
    logic [IDX_W-1:0]   idx;
    logic               tick, done, busy, accept, cmd_wr, data_wr;
    logic [DATA_W-1:0]  rd_word, data_q;
    logic [FIELD_W-1:0] phy_q, reg_q;
    logic               dir_q;

    assign busy    = (state != ST_IDLE);
    assign mdc     = (state == ST_HIGH);
    assign cmd_wr  = host_en && host_we && !host_addr[2];
    assign data_wr = host_en && host_we &&  host_addr[2];
    assign accept  = cmd_wr && host_wdata[0] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_q  <= '0;
            reg_q  <= '0;
            dir_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (accept) begin
                dir_q <= host_wdata[1];
                reg_q <= host_wdata[8:4];
                phy_q <= host_wdata[16:12];
            end
            if (done && !dir_q)
                data_q <= rd_word;
            else if (data_wr)
                data_q <= host_wdata[DATA_W-1:0];
        end
    end

    assign host_rdata = host_addr[2] ? {16'b0, data_q}
                                     : {15'b0, phy_q, 3'b0, reg_q, 2'b0, dir_q, busy};

    mdio_mdc_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(accept), .div_half(div_half), .tick(tick)
    );

    mdio_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(accept), .tick(tick), .dir_wr(dir_q),
        .mdio_i(mdio_i), .state_q(state), .idx_q(idx), .done(done), .rd_word(rd_word)
    );

    mdio_bit_mux u_mux (
        .state(state), .idx(idx), .dir_wr(dir_q), .phy(phy_q), .regn(reg_q),
        .wdata(data_q), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // R3: a command write while busy leaves the stored fields alone
    p_cmd_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ($stable(phy_q) && $stable(reg_q) && $stable(dir_q)))
        else $error("p_cmd_ignored_r3");

    // R6: the line is released from turnaround to the end of a read
    p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dir_q && idx >= IDX_W'(TA_FIRST)) |-> !mdio_oe)
        else $error("p_read_release_r6");

    // R8: idle keeps MDC low and the pin released
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe))
        else $error("p_idle_quiet_r8");

    // R7: a write frame drives the line for every bit
    p_write_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dir_q) |-> mdio_oe)
        else $error("p_write_drives_r7");
endmodule

// File: tb/tb_mdio_cmd_ctrl.sv
module tb_mdio_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_en = 1'b0, host_we = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic [7:0]  div_half = 8'd9;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_drv = 1'b0, phy_val = 1'b1;
    logic        mdio_line;

    int checks = 0, errors = 0, cycles = 0;
    int nrise = 0;
    logic [63:0] cap = '0;
    logic        rd_mode = 1'b0;
    logic [15:0] phy_data = '0;
    logic        oe_seen_read = 1'b0;
    logic        contention = 1'b0;
    time         t_rise1 = 0, t_rise2 = 0;

    always #10 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    mdio_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .div_half(div_half), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_line)
    );

    // behavioural PHY
    always @(posedge mdc) begin
        if (rd_mode && nrise >= 46 && mdio_oe) oe_seen_read = 1'b1;
        cap = {cap[62:0], mdio_line};
        nrise = nrise + 1;
        if (nrise == 1) t_rise1 = $time;
        if (nrise == 2) t_rise2 = $time;
    end

    always @(negedge mdc) begin
        if (rd_mode && nrise == 47) begin
            phy_drv = 1'b1; phy_val = 1'b0;
        end else if (rd_mode && nrise >= 48 && nrise <= 63) begin
            phy_drv = 1'b1; phy_val = phy_data[63 - nrise];
        end else begin
            phy_drv = 1'b0; phy_val = 1'b1;
        end
    end

    always @(negedge clk) if (mdio_oe && phy_drv) contention = 1'b1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
    endfunction

    task automatic host_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0; host_addr = 3'd0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
        host_addr = 3'd0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            #1;
            if (host_rdata[0] == 1'b0) break;
        end
    endtask

    function automatic logic [31:0] cmd_word(input bit wr, input logic [4:0] phy,
                                             input logic [4:0] rg);
        return {15'b0, phy, 3'b0, rg, 2'b0, wr, 1'b1};
    endfunction

    task automatic prep(input bit rd, input logic [15:0] v);
        nrise = 0; cap = '0; rd_mode = rd; phy_data = v;
        oe_seen_read = 1'b0; contention = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        host_read(3'd0, r);
        chk(r == 32'd0, "R9 cmd after reset", {32'd0, r}, 64'd0);
        chk(!mdc && !mdio_oe, "R9 pins after reset", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_write_next_cycle();
        logic [31:0] r;
        prep(1'b0, 16'h0);
        host_write(3'd0, cmd_word(1'b1, 5'h13, 5'h0A));
        host_write(3'd4, 32'h0000_A5C3);
        host_read(3'd0, r);
        chk(r == {15'b0, 5'h13, 3'b0, 5'h0A, 2'b0, 1'b1, 1'b1}, "R1 R2 cmd readback busy",
            {32'd0, r}, {32'd0, 15'b0, 5'h13, 3'b0, 5'h0A, 2'b0, 2'b11});
        wait_idle();
        host_read(3'd0, r);
        chk(r[0] == 1'b0, "R2 busy clears", {63'd0, r[0]}, 64'd0);
        chk(nrise == 64, "R4 write rising edges", 64'(nrise), 64'd64);
        chk(cap == exp_frame(1'b1, 5'h13, 5'h0A, 16'hA5C3), "R4 R7 write frame",
            cap, exp_frame(1'b1, 5'h13, 5'h0A, 16'hA5C3));
        chk(t_rise2 - t_rise1 == 400, "R8 MDC period div 9", 64'(t_rise2 - t_rise1), 64'd400);
        host_read(3'd4, r);
        chk(r == 32'h0000_A5C3, "R5 data readback", {32'd0, r}, 64'h A5C3);
    endtask

    task automatic t_write_late_data();
        host_write(3'd4, 32'h0000_1111);
        prep(1'b0, 16'h0);
        host_write(3'd0, cmd_word(1'b1, 5'h1F, 5'h00));
        repeat (200) @(negedge clk);
        host_write(3'd4, 32'h0000_3C5A);
        wait_idle();
        chk(cap == exp_frame(1'b1, 5'h1F, 5'h00, 16'h3C5A), "R5 late data sent",
            cap, exp_frame(1'b1, 5'h1F, 5'h00, 16'h3C5A));
        chk(!contention, "R7 no contention on write", {63'd0, contention}, 64'd0);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] v, input logic [7:0] dh);
        logic [31:0] r;
        div_half = dh;
        prep(1'b1, v);
        host_write(3'd0, cmd_word(1'b0, phy, rg));
        wait_idle();
        chk(nrise == 64, "R4 read rising edges", 64'(nrise), 64'd64);
        chk(cap == exp_frame(1'b0, phy, rg, v), "R4 R6 read frame",
            cap, exp_frame(1'b0, phy, rg, v));
        chk(!oe_seen_read, "R6 line released", {63'd0, oe_seen_read}, 64'd0);
        chk(!contention, "R6 no contention", {63'd0, contention}, 64'd0);
        host_read(3'd4, r);
        chk(r == {16'd0, v}, "R6 read result", {32'd0, r}, {48'd0, v});
        chk(64'(t_rise2 - t_rise1) == 64'(40 * (dh + 1)), "R8 MDC period",
            64'(t_rise2 - t_rise1), 64'(40 * (dh + 1)));
        chk(!mdc && !mdio_oe, "R8 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_ignore_busy();
        logic [31:0] r;
        div_half = 8'd9;
        prep(1'b1, 16'h5A0F);
        host_write(3'd0, cmd_word(1'b0, 5'h02, 5'h11));
        repeat (300) @(negedge clk);
        host_write(3'd0, cmd_word(1'b1, 5'h1C, 5'h07));
        host_read(3'd0, r);
        chk(r == {15'b0, 5'h02, 3'b0, 5'h11, 2'b0, 1'b0, 1'b1}, "R3 fields kept",
            {32'd0, r}, {32'd0, 15'b0, 5'h02, 3'b0, 5'h11, 4'b0001});
        wait_idle();
        repeat (100) @(negedge clk);
        chk(nrise == 64, "R3 single frame", 64'(nrise), 64'd64);
        chk(cap == exp_frame(1'b0, 5'h02, 5'h11, 16'h5A0F), "R3 frame unaltered",
            cap, exp_frame(1'b0, 5'h02, 5'h11, 16'h5A0F));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_next_cycle();
        t_write_late_data();
        t_read(5'h01, 5'h1F, 16'hBEEF, 8'd9);
        t_read(5'h10, 5'h03, 16'h0001, 8'd14);
        t_ignore_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule